// File: doc/BRIEF.md
# Frame Buffer Scan-Out Controller

This block streams one fixed 640x480 true-color frame out of a linear frame buffer in memory. Every visible pixel occupies one 32-bit word. The block forms that word's byte address and issues a read on a simple valid/ready request port. It takes the in-order response and places it in a short pixel buffer. On each pixel strobe from an external display timing generator, it presents the pixel's red, green and blue bytes. The block makes no sync timing of its own. Frame-start and line-start strobes from the timing generator set the scan position.

Software controls the block through two 32-bit write registers, selected by a word index. Word 0 holds the frame-buffer base address. Word 1 holds the control bits: bit 0 enables the display and bit 1 turns the picture through 180 degrees. The base address and the rotation are copied into shadow copies at frame start, so one frame always shows one consistent image. Rows sit 1024 words apart in memory, and only their first 640 words are read. If a pixel strobe arrives before its data, that pixel is shown black and a sticky underrun flag is raised.

Top module: `fb_scanout`

## Requirements
- R1: After reset, both registers are zero. No read request is raised, all three color outputs are 0 and the underrun flag is 0.
- R2: A write to word 0 keeps only bits 31:21 of the value and clears bits 20:0. The first request after a frame start addresses that masked base exactly.
- R3: With rotation off, pixel column c of display row r is fetched from byte address base + r*4096 + c*4, for c from 0 to 639 in order. Frame start sets r to 0. Each line start adds 1 to r and discards any pixel data that is buffered or still in flight.
- R4: With rotation on, display column c of row r is fetched from memory column 639-c of memory row 479-r. The first pixel of a frame is therefore memory pixel (639, 479).
- R5: The pixel chosen by a pixel strobe appears on the outputs one clock after the strobe. Red comes from word bits 23:16, green from bits 15:8 and blue from bits 7:0. Bits 31:24 have no effect on the colors.
- R6: A pixel strobe at column 640 or beyond, or on a row at 480 or beyond, outputs black and uses no buffered data. No request is raised for rows at 480 or beyond.
- R7: Writing word 1 with bit 0 clear stops all requests from the next cycle and forces all colors to 0. Setting bit 0 again starts fetching only at the next frame start.
- R8: Base and rotation written during a frame take effect only at the next frame start. Line starts in between keep the old base and scan direction.
- R9: A visible pixel strobe that finds the buffer empty outputs black and sets the underrun flag. The flag stays set until word 1 is written.
- R10: While a request is valid and not accepted, its address holds steady until a frame or line start.
- R11: Buffered pixels plus outstanding reads never exceed the buffer depth, so a response never arrives to a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_word | input | 1 | Register select: 0 base, 1 control |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Start of frame strobe, also begins row 0 |
| line_start | input | 1 | Start of next row strobe |
| pix_en | input | 1 | Pixel strobe, one per displayed pixel position |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid, returned in request order |
| mem_rsp_data | input | 32 | Read data word |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |
| underrun | output | 1 | Sticky flag for a pixel shown before its data arrived |

## Verification
Assertions check the following on every cycle: the request address holds while stalled, the buffer-plus-outstanding bound, the drop counter never exceeding the outstanding count, requests stopping after a disabling write, and the underrun flag staying set until a control write. Address arithmetic, channel extraction and the mirrored rotated scan can only be shown by scenarios that compare output colors against an independently computed address. The same holds for the frame-start shadowing, the discard of stale data at a line start and the blanking past column 639 or row 479.

// File: rtl/fb_pkg.sv
package fb_pkg;
   localparam int REG_W        = 32;
   localparam int CH_W         = 8;
   localparam int PIX_W        = 3 * CH_W;
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_ROT_BIT = 1;

   typedef struct packed {
      logic [CH_W-1:0] r;
      logic [CH_W-1:0] g;
      logic [CH_W-1:0] b;
   } rgb_t;

   function automatic rgb_t unpack_pix(input logic [PIX_W-1:0] w);
      rgb_t p;
      p.r = w[3*CH_W-1:2*CH_W];
      p.g = w[2*CH_W-1:CH_W];
      p.b = w[CH_W-1:0];
      return p;
   endfunction
endpackage

// File: rtl/fb_ctrl_regs.sv
module fb_ctrl_regs
   import fb_pkg::*;
#(
   parameter int KEEP_BITS = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_word,
   input  logic [REG_W-1:0] wr_data,
   input  logic             frame_start,
   output logic             en_o,
   output logic             active_o,
   output logic [REG_W-1:0] base_sh_o,
   output logic             rot_sh_o,
   output logic             ctrl_wr_o
);
   localparam logic [REG_W-1:0] BASE_MASK = ~((REG_W'(1) << (REG_W - KEEP_BITS)) - REG_W'(1));

   if (KEEP_BITS < 1 || KEEP_BITS > REG_W) begin : g_bad_keep
      $error("KEEP_BITS out of range");
   end

   logic [REG_W-1:0] base_q;
   logic             en_q, rot_q, armed_q;

   assign ctrl_wr_o = wr_en && wr_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q    <= '0;
         en_q      <= 1'b0;
         rot_q     <= 1'b0;
         base_sh_o <= '0;
         rot_sh_o  <= 1'b0;
         armed_q   <= 1'b0;
      end else begin
         if (wr_en && !wr_word) base_q <= wr_data & BASE_MASK;
         if (ctrl_wr_o) begin
            en_q  <= wr_data[CTRL_EN_BIT];
            rot_q <= wr_data[CTRL_ROT_BIT];
         end
         if (frame_start) begin
            base_sh_o <= base_q;
            rot_sh_o  <= rot_q;
            armed_q   <= en_q;
         end else if (!en_q) begin
            armed_q <= 1'b0;
         end
      end
   end

   assign en_o     = en_q;
   assign active_o = en_q && armed_q;
endmodule

// File: rtl/fb_pix_fifo.sv
module fb_pix_fifo #(
   parameter int WIDTH = 24,
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CNT_W-1:0] count,
   output logic             empty
);
   if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end

   assign empty = (count == '0);

   if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            count <= '0;
         end else if (push) begin
            count <= CNT_W'(1);
         end else if (pop) begin
            count <= '0;
         end
      end
      always_ff @(posedge clk) begin
         if (push) hold_q <= wdata;
      end
      assign rdata = hold_q;
   end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      logic [WIDTH-1:0] mem_q [DEPTH];
      logic [AW-1:0]    wp_q, rp_q;
      logic             pop_ok;
      assign pop_ok = pop && !empty;
      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
         end else begin
            if (push)   wp_q <= wp_q + AW'(1);
            if (pop_ok) rp_q <= rp_q + AW'(1);
            count <= count + CNT_W'(push) - CNT_W'(pop_ok);
         end
      end
      always_ff @(posedge clk) begin
         if (push) mem_q[wp_q] <= wdata;
      end
      assign rdata = mem_q[rp_q];
   end

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && !pop) |-> (count < CNT_W'(DEPTH)));
endmodule

// File: rtl/fb_fetch.sv
module fb_fetch
   import fb_pkg::*;
#(
   parameter int H_VIS       = 640,
   parameter int V_VIS       = 480,
   parameter int PITCH_WORDS = 1024,
   parameter int DEPTH       = 8,
   localparam int X_W       = $clog2(H_VIS + 1),
   localparam int Y_W       = $clog2(V_VIS + 1),
   localparam int CNT_W     = $clog2(DEPTH + 1),
   localparam int ROW_SHIFT = $clog2(PITCH_WORDS) + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             restart,
   input  logic [Y_W-1:0]   row,
   input  logic [REG_W-1:0] base_sh,
   input  logic             rot_sh,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic             rsp_valid,
   input  logic             req_ready,
   output logic             req_valid,
   output logic [REG_W-1:0] req_addr,
   output logic             push
);
   if (PITCH_WORDS < H_VIS || (PITCH_WORDS & (PITCH_WORDS - 1)) != 0) begin : g_bad_pitch
      $error("PITCH_WORDS must be a power of two no smaller than H_VIS");
   end

   logic [X_W-1:0]   fx_q, mem_col;
   logic [Y_W-1:0]   mem_row;
   logic [CNT_W-1:0] outst_q, drop_q, outst_nx;
   logic [CNT_W:0]   in_use;
   logic             fire;

   assign in_use    = (CNT_W+1)'(fifo_count) + (CNT_W+1)'(outst_q);
   assign req_valid = active && (row < Y_W'(V_VIS)) && (fx_q < X_W'(H_VIS))
                      && (in_use < (CNT_W+1)'(DEPTH));
   assign fire      = req_valid && req_ready;
   assign outst_nx  = outst_q + CNT_W'(fire) - CNT_W'(rsp_valid);

   assign mem_col  = rot_sh ? X_W'(H_VIS - 1) - fx_q : fx_q;
   assign mem_row  = rot_sh ? Y_W'(V_VIS - 1) - row  : row;
   assign req_addr = base_sh | (REG_W'(mem_row) << ROW_SHIFT) | (REG_W'(mem_col) << 2);

   assign push = rsp_valid && (drop_q == '0) && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fx_q    <= '0;
         outst_q <= '0;
         drop_q  <= '0;
      end else begin
         outst_q <= outst_nx;
         if (restart) begin
            fx_q   <= '0;
            drop_q <= outst_nx;
         end else begin
            if (fire) fx_q <= fx_q + X_W'(1);
            if (rsp_valid && drop_q != '0) drop_q <= drop_q - CNT_W'(1);
         end
      end
   end

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !restart) |=> $stable(req_addr));
   // R3
   drop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_q <= outst_q);
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
   import fb_pkg::*;
#(
   parameter int H_VIS       = 640,
   parameter int V_VIS       = 480,
   parameter int PITCH_WORDS = 1024,
   parameter int KEEP_BITS   = 11,
   parameter int BUF_DEPTH   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic             reg_word,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             frame_start,
   input  logic             line_start,
   input  logic             pix_en,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [REG_W-1:0] mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [REG_W-1:0] mem_rsp_data,
   output logic [CH_W-1:0]  red,
   output logic [CH_W-1:0]  green,
   output logic [CH_W-1:0]  blue,
   output logic             underrun
);
   localparam int X_W   = $clog2(H_VIS + 1);
   localparam int Y_W   = $clog2(V_VIS + 1);
   localparam int CNT_W = $clog2(BUF_DEPTH + 1);

   if (longint'(V_VIS) * PITCH_WORDS * 4 > (longint'(1) << (REG_W - KEEP_BITS))) begin : g_bad_span
      $error("frame does not fit below the kept base bits");
   end

   logic             en, active, rot_sh, ctrl_wr, restart, push, pop, empty, visible;
   logic [REG_W-1:0] base_sh;
   logic [Y_W-1:0]   row_q;
   logic [X_W-1:0]   col_q;
   logic [CNT_W-1:0] fifo_count;
   logic [PIX_W-1:0] fifo_rdata;
   rgb_t             pix_q;
   logic             under_q;

   assign restart = frame_start || line_start;

   fb_ctrl_regs #(.KEEP_BITS(KEEP_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_word(reg_word), .wr_data(reg_wdata),
      .frame_start(frame_start), .en_o(en), .active_o(active), .base_sh_o(base_sh),
      .rot_sh_o(rot_sh), .ctrl_wr_o(ctrl_wr));

   fb_fetch #(.H_VIS(H_VIS), .V_VIS(V_VIS), .PITCH_WORDS(PITCH_WORDS), .DEPTH(BUF_DEPTH)) u_fetch (
      .clk(clk), .rst_n(rst_n), .active(active), .restart(restart), .row(row_q),
      .base_sh(base_sh), .rot_sh(rot_sh), .fifo_count(fifo_count), .rsp_valid(mem_rsp_valid),
      .req_ready(mem_req_ready), .req_valid(mem_req_valid), .req_addr(mem_req_addr), .push(push));

   fb_pix_fifo #(.WIDTH(PIX_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(restart), .push(push), .wdata(mem_rsp_data[PIX_W-1:0]),
      .pop(pop), .rdata(fifo_rdata), .count(fifo_count), .empty(empty));

   assign visible = active && (row_q < Y_W'(V_VIS)) && (col_q < X_W'(H_VIS));
   assign pop     = pix_en && !restart && visible && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q   <= '0;
         col_q   <= '0;
         pix_q   <= '0;
         under_q <= 1'b0;
      end else begin
         if (frame_start) begin
            row_q <= '0;
            col_q <= '0;
         end else if (line_start) begin
            if (row_q != Y_W'(V_VIS)) row_q <= row_q + Y_W'(1);
            col_q <= '0;
         end else if (pix_en) begin
            if (col_q != X_W'(H_VIS)) col_q <= col_q + X_W'(1);
            pix_q <= pop ? unpack_pix(fifo_rdata) : '0;
         end
         if (pix_en && !restart && visible && empty) under_q <= 1'b1;
         else if (ctrl_wr)                           under_q <= 1'b0;
      end
   end

   assign red      = en ? pix_q.r : '0;
   assign green    = en ? pix_q.g : '0;
   assign blue     = en ? pix_q.b : '0;
   assign underrun = under_q;

   // R7
   stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_word && !reg_wdata[CTRL_EN_BIT]) |=> !mem_req_valid);
   // R9
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !(reg_wr_en && reg_word)) |=> underrun);
endmodule

// File: tb/fb_scanout_test.sv
module fb_scanout_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0, reg_word = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        frame_start = 1'b0, line_start = 1'b0, pix_en = 1'b0;
   logic        mem_req_valid, mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic [7:0]  red, green, blue;
   logic        underrun;
   logic        mem_stall = 1'b0;
   int          checks = 0, errors = 0;
   logic [31:0] mq[$];

   always #2 clk = ~clk;

   assign mem_req_ready = !mem_stall;

   fb_scanout uut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_word(reg_word), .reg_wdata(reg_wdata),
      .frame_start(frame_start), .line_start(line_start), .pix_en(pix_en),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .red(red), .green(green), .blue(blue), .underrun(underrun));

   // memory model: one-cycle latency, in order, junk in bits 31:24
   always @(posedge clk) begin
      if (mem_req_valid && mem_req_ready) mq.push_back(mem_req_addr);
   end
   always @(negedge clk) begin
      if (mq.size() > 0 && !mem_stall) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = {8'hC3, mq[0][23:0]};
         void'(mq.pop_front());
      end else begin
         mem_rsp_valid = 1'b0;
      end
   end

   function automatic logic [23:0] exp_rgb(input logic rot, input logic [31:0] base,
                                           input int row, input int col);
      int mr, mc;
      logic [31:0] a;
      mr = rot ? 479 - row : row;
      mc = rot ? 639 - col : col;
      a  = base | (32'(mr) << 12) | (32'(mc) << 2);
      return a[23:0];
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic word, input logic [31:0] d);
      @(negedge clk); reg_wr_en = 1'b1; reg_word = word; reg_wdata = d;
      @(negedge clk); reg_wr_en = 1'b0;
   endtask

   task automatic pulse_frame;
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
   endtask

   task automatic pulse_line;
      @(negedge clk); line_start = 1'b1;
      @(negedge clk); line_start = 1'b0;
   endtask

   task automatic pix(input logic [23:0] exp, input string tag);
      @(negedge clk); pix_en = 1'b1;
      @(negedge clk); pix_en = 1'b0;
      check({red, green, blue} == exp, tag, {8'h0, red, green, blue}, {8'h0, exp});
   endtask

   task automatic t_reset;
      check(!mem_req_valid, "R1 req idle", 32'(mem_req_valid), 0);
      check({red, green, blue} == 0, "R1 colors", {8'h0, red, green, blue}, 0);
      check(!underrun, "R1 underrun", 32'(underrun), 0);
   endtask

   task automatic t_base_and_line0;
      wr(1'b0, 32'h1234_5678);
      wr(1'b1, 32'h1);
      pulse_frame;
      check(mem_req_valid, "R2 first req valid", 32'(mem_req_valid), 1);
      check(mem_req_addr == 32'h1220_0000, "R2 masked base", mem_req_addr, 32'h1220_0000);
      idle(12);
      // R3 R5 R6: full line, then blank columns
      for (int c = 0; c < 700; c++)
         pix(c < 640 ? exp_rgb(1'b0, 32'h1220_0000, 0, c) : 24'h0, c < 640 ? "R3 R5 line0" : "R6 past col");
      check(!underrun, "R9 no underrun line0", 32'(underrun), 0);
   endtask

   task automatic t_next_row;
      pulse_line;
      idle(12);
      for (int c = 0; c < 5; c++) pix(exp_rgb(1'b0, 32'h1220_0000, 1, c), "R3 row1 restart");
   endtask

   task automatic t_shadow_and_rotate;
      wr(1'b0, 32'h4000_0000);
      wr(1'b1, 32'h3);
      pulse_line;
      idle(12);
      for (int c = 0; c < 4; c++) pix(exp_rgb(1'b0, 32'h1220_0000, 2, c), "R8 old base kept");
      pulse_frame;
      check(mem_req_addr == 32'h401D_F9FC, "R4 first rotated addr", mem_req_addr, 32'h401D_F9FC);
      idle(12);
      for (int c = 0; c < 6; c++) pix(exp_rgb(1'b1, 32'h4000_0000, 0, c), "R4 R8 rotated");
   endtask

   task automatic t_last_rows;
      pulse_frame;
      for (int r = 0; r < 479; r++) pulse_line;
      idle(12);
      pix(exp_rgb(1'b1, 32'h4000_0000, 479, 0), "R4 last row");
      pix(exp_rgb(1'b1, 32'h4000_0000, 479, 1), "R4 last row");
      pulse_line;
      idle(4);
      check(!mem_req_valid, "R6 no req past row", 32'(mem_req_valid), 0);
      pix(24'h0, "R6 past row black");
      check(!underrun, "R6 no underrun past row", 32'(underrun), 0);
   endtask

   task automatic t_underrun;
      logic [31:0] held;
      mem_stall = 1'b1;
      pulse_frame;
      idle(3);
      held = mem_req_addr;
      check(mem_req_valid, "R10 stalled valid", 32'(mem_req_valid), 1);
      idle(4);
      check(mem_req_addr == held, "R10 addr held", mem_req_addr, held);
      pix(24'h0, "R9 underrun black");
      check(underrun, "R9 flag set", 32'(underrun), 1);
      mem_stall = 1'b0;
      idle(6);
      check(underrun, "R9 flag sticky", 32'(underrun), 1);
      wr(1'b1, 32'h3);
      check(!underrun, "R9 cleared by ctrl write", 32'(underrun), 0);
   endtask

   task automatic t_disable;
      pulse_frame;
      idle(12);
      pix(exp_rgb(1'b1, 32'h4000_0000, 0, 0), "R5 before disable");
      wr(1'b1, 32'h0);
      check(!mem_req_valid, "R7 req stops", 32'(mem_req_valid), 0);
      check({red, green, blue} == 0, "R7 colors zero", {8'h0, red, green, blue}, 0);
      pix(24'h0, "R7 disabled pixel");
      check(!underrun, "R7 no underrun when off", 32'(underrun), 0);
      wr(1'b1, 32'h1);
      idle(5);
      check(!mem_req_valid, "R7 waits for frame", 32'(mem_req_valid), 0);
      pulse_frame;
      check(mem_req_valid, "R7 resumes at frame", 32'(mem_req_valid), 1);
      check(mem_req_addr == 32'h4000_0000, "R8 new base unrotated", mem_req_addr, 32'h4000_0000);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_base_and_line0;
      t_next_row;
      t_shadow_and_rotate;
      t_last_rows;
      t_underrun;
      t_disable;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule